// File: doc/BRIEF.md
# Leading-One Aligned Multicycle Unsigned Divider

This block divides one unsigned integer by another and returns both the quotient and the remainder. A one-cycle `start` request loads the dividend and the divisor. The block then measures how many leading zeros each operand has and shifts the divisor left so that its top set bit lines up with the top set bit of the dividend. After that it runs exactly as many conditional-subtract steps as the alignment requires. Small quotients therefore finish in a few cycles, and only a divisor of one against a dividend with the top bit set uses the full width.

Each step compares a working register with the aligned divisor. When the working value is not smaller, the block subtracts the divisor, shifts the difference left and sets the new low bit. When it is smaller, the block only shifts the value left. Quotient bits build up from the bottom of the working register while the partial remainder moves upward. Three operand patterns skip the loop altogether: a zero dividend, a zero divisor, and a divisor larger than the dividend. The working register is one bit wider than the operands, so a dividend with its top bit set loses nothing in the shift.

A result is reported by a one-cycle `done` pulse. The quotient and remainder outputs then keep their values until the next division completes. `busy` is high from the cycle after a request is accepted until the cycle in which `done` rises, and `start` has no effect while `busy` is high.

Top module: `lead_align_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: For a non-zero dividend N and a non-zero divisor D with D <= N, the outputs give `quotient` = N / D and `remainder` = N % D, truncated integer division.
- R3: For the case of R2, let s be the leading-zero count of D minus the leading-zero count of N, each counted over the full operand width. Then `done` is high in the cycle after the (s+3)-th rising edge that follows the edge which accepted `start`.
- R4: If the divisor is greater than a non-zero dividend, `quotient` is 0 and `remainder` equals the dividend. `done` is high in the cycle after the 2nd edge that follows acceptance.
- R5: A zero dividend gives `quotient` 0 and `remainder` 0 for any divisor, the zero divisor included, with the same 2-edge latency as R4.
- R6: A zero divisor with a non-zero dividend gives a `quotient` of all ones and a `remainder` equal to the dividend, with the same 2-edge latency as R4.
- R7: `done` is high for exactly one cycle per accepted request and is never high while `busy` is high. `quotient` and `remainder` keep their values after `done` until the next completion.
- R8: A `start` pulse presented while `busy` is high is ignored. The running division completes with the operands it accepted, and no extra `done` pulse follows.
- R9: Dividends with the top bit set, up to all ones, divide correctly, including by a divisor of 1, which needs the full width of steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only when `busy` is low |
| dividend | input | W | Unsigned numerator, sampled when the request is accepted |
| divisor | input | W | Unsigned denominator, sampled when the request is accepted |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | W | Quotient of the last completed division |
| remainder | output | W | Remainder of the last completed division |

## Verification
The assertions check several things on every cycle:
- each working value entering a step is below twice the aligned divisor;
- every remainder produced by the loop is below the original divisor;
- `done` is a single-cycle pulse that never overlaps `busy`;
- `busy` rises only after a request;
- the step loop keeps running while steps remain.

Exact quotient and remainder values, the data-dependent latency and the treatment of requests made while busy can only be shown by the bench's scenarios. These are an exhaustive sweep of every operand pair on a 6-bit instance, plus corner values and random operands on the 32-bit instance.

// File: rtl/div_pkg.sv
package div_pkg;

  // Strobes issued by the sequencer to the datapath, at most one high per cycle.
  typedef struct packed {
    logic load;    // capture operands
    logic align;   // classify operands, align divisor, seed working register
    logic step;    // one conditional-subtract step
    logic finish;  // extract quotient and remainder into output registers
  } div_strobe_t;

endpackage

// File: rtl/lead_zero_count.sv
module lead_zero_count #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] count
);

  // Scan upward so the highest set bit writes last; all-zero input yields W.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1),
  localparam int WW = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  div_strobe_t   strobe,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic [CW-1:0] shiftAmt,
  output logic          special,
  output logic [W-1:0]  quotient,
  output logic [W-1:0]  remainder
);

  logic [W-1:0]  numReg, denReg;
  logic [WW-1:0] workReg;
  logic [CW-1:0] shReg;
  logic          specFlag;
  logic [W-1:0]  specQ, specR;
  logic [W-1:0]  qReg, rReg;

  logic [CW-1:0] lzcNum, lzcDen;

  lead_zero_count #(.W(W)) u_lzcNum (.value(numReg), .count(lzcNum));
  lead_zero_count #(.W(W)) u_lzcDen (.value(denReg), .count(lzcDen));

  // Operand classification, valid in the align cycle.
  logic numZero, denZero, denAbove;
  assign numZero  = (numReg == '0);
  assign denZero  = (denReg == '0);
  assign denAbove = (denReg > numReg);
  assign special  = numZero || denZero || denAbove;
  assign shiftAmt = lzcDen - lzcNum;

  // Conditional-subtract step.
  logic          stepGeq;
  logic [W-1:0]  stepDiff;
  logic [WW-1:0] stepNext;
  assign stepGeq  = (workReg >= {1'b0, denReg});
  assign stepDiff = workReg[W-1:0] - denReg;
  assign stepNext = stepGeq ? {stepDiff, 1'b1} : {workReg[W-1:0], 1'b0};

  // Result extraction: low (s+1) bits are the quotient, the rest the remainder.
  logic [CW-1:0] stepsRun;
  logic [W-1:0]  qMask, qExt, rExt;
  assign stepsRun = shReg + CW'(1);
  assign qMask    = (W'(1) << stepsRun) - W'(1);
  assign qExt     = workReg[W-1:0] & qMask;
  assign rExt     = W'(workReg >> stepsRun);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      numReg   <= '0;
      denReg   <= '0;
      workReg  <= '0;
      shReg    <= '0;
      specFlag <= 1'b0;
      specQ    <= '0;
      specR    <= '0;
      qReg     <= '0;
      rReg     <= '0;
    end else begin
      if (strobe.load) begin
        numReg <= dividend;
        denReg <= divisor;
      end
      if (strobe.align) begin
        workReg  <= {1'b0, numReg};
        specFlag <= special;
        shReg    <= special ? '0 : shiftAmt;
        if (!special) denReg <= denReg << shiftAmt;
        if (numZero) begin
          specQ <= '0;
          specR <= '0;
        end else if (denZero) begin
          specQ <= '1;
          specR <= numReg;
        end else begin
          specQ <= '0;
          specR <= numReg;
        end
      end
      if (strobe.step) workReg <= stepNext;
      if (strobe.finish) begin
        qReg <= specFlag ? specQ : qExt;
        rReg <= specFlag ? specR : rExt;
      end
    end
  end

  assign quotient  = qReg;
  assign remainder = rReg;

  // R2: aligned loop invariant, working value below twice the divisor.
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.step |-> (workReg < {denReg, 1'b0}));

  // R2: loop remainder is below the unaligned divisor.
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.finish && !specFlag) |-> (rExt < (denReg >> shReg)));

endmodule

// File: rtl/div_control.sv
module div_control
  import div_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          special,
  input  logic [CW-1:0] shiftAmt,
  output div_strobe_t   strobe,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STEP, S_FINISH} ctrl_state_t;

  ctrl_state_t   state;
  logic [CW-1:0] stepsLeft;

  always_comb begin
    strobe        = '0;
    strobe.load   = (state == S_IDLE) && start;
    strobe.align  = (state == S_SETUP);
    strobe.step   = (state == S_STEP);
    strobe.finish = (state == S_FINISH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      stepsLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= (state == S_FINISH);
      case (state)
        S_IDLE:   if (start) state <= S_SETUP;
        S_SETUP: begin
          if (special) begin
            state <= S_FINISH;
          end else begin
            stepsLeft <= shiftAmt;
            state     <= S_STEP;
          end
        end
        S_STEP: begin
          if (stepsLeft == '0) state <= S_FINISH;
          else stepsLeft <= stepsLeft - CW'(1);
        end
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // R7: done lasts one cycle.
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done never overlaps busy.
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: busy only rises after a request.
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3: the loop keeps stepping while steps remain.
  a_r3_loop_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STEP && stepsLeft != '0) |=> (state == S_STEP));

endmodule

// File: rtl/lead_align_divider.sv
module lead_align_divider
  import div_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  div_strobe_t   strobe;
  logic          special;
  logic [CW-1:0] shiftAmt;

  div_control #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .special(special),
    .shiftAmt(shiftAmt), .strobe(strobe), .busy(busy), .done(done)
  );

  div_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .dividend(dividend),
    .divisor(divisor), .shiftAmt(shiftAmt), .special(special),
    .quotient(quotient), .remainder(remainder)
  );

endmodule

// File: tb/sim_lead_align_divider.sv
`timescale 1ns/1ps
module sim_lead_align_divider;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic        s0 = 1'b0, s1 = 1'b0;
  logic [31:0] a0 = '0, b0 = '0;
  logic [5:0]  a1 = '0, b1 = '0;
  logic        busy0, done0, busy1, done1;
  logic [31:0] q0, r0;
  logic [5:0]  q1, r1;

  lead_align_divider #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(s0), .dividend(a0), .divisor(b0),
    .busy(busy0), .done(done0), .quotient(q0), .remainder(r0)
  );

  lead_align_divider #(.W(6)) u1 (
    .clk(clk), .rst_n(rst_n), .start(s1), .dividend(a1), .divisor(b1),
    .busy(busy1), .done(done1), .quotient(q1), .remainder(r1)
  );

  bit          sel6 = 1'b0;
  logic        doneSel, busySel;
  logic [31:0] qSel, rSel;
  always_comb begin
    doneSel = sel6 ? done1 : done0;
    busySel = sel6 ? busy1 : busy0;
    qSel    = sel6 ? {26'b0, q1} : q0;
    rSel    = sel6 ? {26'b0, r1} : r0;
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lzc(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return w - 1 - i;
    return w;
  endfunction

  task automatic drive(input int w, input logic st, input logic [31:0] n, input logic [31:0] d);
    if (w == 32) begin s0 = st; a0 = n; b0 = d; end
    else begin s1 = st; a1 = n[5:0]; b1 = d[5:0]; end
  endtask

  // Cycle count is taken at falling edges; the falling edge after the accepting
  // rising edge counts as 1, so done after the k-th following edge reads as k+1.
  task automatic runOne(input int w, input logic [31:0] n, input logic [31:0] d, input bit poke);
    logic [31:0] eq, er, mask;
    int lat, cyc;
    string tag;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    if (n == 0) begin
      eq = 0; er = 0; lat = 3; tag = "R5";
    end else if (d == 0) begin
      eq = mask; er = n; lat = 3; tag = "R6";
    end else if (d > n) begin
      eq = 0; er = n; lat = 3; tag = "R4";
    end else begin
      eq = n / d; er = n % d;
      lat = lzc(d, w) - lzc(n, w) + 4;
      tag = n[w-1] ? "R9" : "R2";
    end
    @(negedge clk);
    sel6 = (w != 32);
    drive(w, 1'b1, n, d);
    @(negedge clk);
    drive(w, 1'b0, n, d);
    cyc = 1;
    if (poke) begin
      drive(w, 1'b1, ~n, n ^ d ^ 32'h5A5A_5A5A);
      @(negedge clk);
      drive(w, 1'b0, 0, 0);
      cyc = 2;
    end
    while (!doneSel && cyc < 80) begin
      @(negedge clk);
      cyc++;
    end
    check(doneSel, 1'b1, tag, "done seen");
    check(cyc, lat, (tag == "R2" || tag == "R9") ? "R3" : tag, "latency");
    check(qSel, eq, tag, "quotient");
    check(rSel, er, tag, "remainder");
    if (poke) begin
      repeat (4) begin
        @(negedge clk);
        check({busySel, doneSel}, 2'b00, "R8", "no extra run after ignored start");
      end
      check(qSel, eq, "R7", "quotient held");
      check(rSel, er, "R7", "remainder held");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] corner [6];
    corner[0] = 32'h0;        corner[1] = 32'h1;
    corner[2] = 32'h2;        corner[3] = 32'hFFFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h1234_5678;

    repeat (3) @(negedge clk);
    // R1: reset state on both instances
    check({busy0, done0}, 2'b00, "R1", "busy/done 32");
    check(q0, 0, "R1", "quotient 32");
    check(r0, 0, "R1", "remainder 32");
    check({busy1, done1, q1, r1}, 0, "R1", "outputs 6");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Corner pairs on the wide instance, including equal operands.
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        runOne(32, corner[i], corner[j], ((i + j) % 3) == 0);

    runOne(32, 32'hFFFF_FFFF, 32'd1, 1'b1);  // R9 full-width loop
    runOne(32, 32'h8000_0001, 32'd3, 1'b0);  // R9

    // Random operands, divisors scaled down for long loops.
    for (int k = 0; k < 300; k++) begin
      logic [31:0] n, d;
      n = $urandom;
      if (k % 4 == 0) n = n >> ($urandom % 32);
      d = $urandom >> ($urandom % 32);
      runOne(32, n, d, (k % 7) == 0);
    end

    // Exhaustive sweep of the narrow instance.
    for (int n = 0; n < 64; n++)
      for (int d = 0; d < 64; d++)
        runOne(6, 32'(n), 32'(d), ((n * 64 + d) % 97) == 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule